// File: doc/BRIEF.md
# Bit-Serial Signed Weighted-Sum Reduction Row

This block reduces one row of `N` signed weights, each gated by a binary input bit, to a single signed sum. A 1 on an input bit adds the weight; a 0 subtracts it. That is the bipolar product a binary-state associative network needs when it forms each neuron's net input. All arithmetic is bit-serial. Each leaf cell picks either the weight or its negation and streams it out least significant bit first. Pairs of streams are then summed by one-bit adders, each holding a carry flip-flop, arranged as a binary tree `log2(N)` levels deep. The root stream is collected into a shift register that presents the sum in parallel.

The operand interface is a valid/ready handshake. One transfer carries the whole row, weights and input bits together. The result leaves on a second valid/ready handshake. The block works on one row at a time. `in_ready` is high only when the block is idle. While a row is being reduced, or while a finished result waits for `out_ready`, the operand handshake is refused and any data offered is ignored. A result stays on `out_sum` with `out_valid` high until `out_ready` is seen at a clock edge. The block is idle from the next cycle.

Top module: `wsum_tree`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Leaf product: an input bit of 1 contributes `+w`, and an input bit of 0 contributes `-w`. Here `w` is the two's complement value of the weight field `in_weights[i*WW +: WW]`, paired with `in_bits[i]`.
- R3: `out_sum` equals the exact signed sum of all `N` leaf products, as a two's complement value `SW = WW + log2(N)` bits wide.
- R4: `out_valid` rises exactly `LAT = SW + log2(N)` clock edges after the edge that accepts the operands. That is 18 for N=8, WW=12. Each doubling of `N` adds two edges.
- R5: From the accepting edge until the result is consumed, `in_ready` is 0. Operands offered during that time neither start a new row nor alter the pending result.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_sum` does not change. After an edge with `out_valid` and `out_ready` both 1, `out_valid` is 0 and `in_ready` is 1.
- R7: All carry and partial-sum state clears when a row is accepted, so a result never depends on the row before it.
- R8: With every weight at an extreme of the legal range (±2047 for WW=12), the sum reaches ±N·2047 without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand row offered |
| in_ready | output | 1 | Block idle; the row is taken at this edge if `in_valid` |
| in_weights | input | N*WW | Packed signed weights; weight i at `[i*WW +: WW]` |
| in_bits | input | N | Binary input bit i selects `+w` (1) or `-w` (0) |
| out_valid | output | 1 | `out_sum` holds a finished result |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | WW+log2(N) | Signed weighted sum |

## Verification
The properties assume that no weight ever takes the most negative code (-2048 for WW=12). Negating that code cannot be represented, and the sum width is chosen for a range that is symmetric about zero. A property checks this at every accepted transfer. The bench draws every random weight from -2047 to +2047, and its directed corner rows stop at ±2047. Random stimulus also holds `out_ready` low for a few cycles and offers junk rows while the block is busy. The assertions take the handshake rules of R5 and R6 as the only protocol the environment follows.

// File: rtl/wsum_pkg.sv
package wsum_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } wsum_state_e;
endpackage

// File: rtl/wsum_serial_node.sv
// Leaf cell: bipolar multiply by selection, then LSB-first parallel-to-serial.
module wsum_serial_node #(
  parameter int WW = 12,
  parameter int SW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic [WW-1:0] weight,
  input  logic          x_bit,
  output logic          ser_bit
);
  localparam int EXT = SW - WW;

  logic [SW-1:0] wext;
  logic [SW-1:0] prod;
  logic [SW-1:0] sr_q;

  // sign-extend first so the negation is taken at full stream width
  assign wext = {{EXT{weight[WW-1]}}, weight};
  assign prod = x_bit ? wext : (~wext + SW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (load)  sr_q <= prod;
    else if (shift) sr_q <= {sr_q[SW-1], sr_q[SW-1:1]};
  end

  assign ser_bit = sr_q[0];
endmodule

// File: rtl/wsum_bit_adder.sv
// Tree node: one full adder, a registered sum bit and a carry flip-flop.
module wsum_bit_adder (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic a,
  input  logic b,
  output logic s
);
  logic carry_q;
  logic sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= 1'b0;
      carry_q <= 1'b0;
    end else if (clr) begin
      sum_q   <= 1'b0;
      carry_q <= 1'b0;
    end else if (en) begin
      sum_q   <= a ^ b ^ carry_q;
      carry_q <= (a & b) | (a & carry_q) | (b & carry_q);
    end
  end

  assign s = sum_q;
endmodule

// File: rtl/wsum_sipo.sv
// Root collector: serial-in, parallel-out, filled LSB first.
module wsum_sipo #(
  parameter int SW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          din,
  output logic [SW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= {din, q[SW-1:1]};
  end
endmodule

// File: rtl/wsum_ctrl.sv
// Sequencer: idle -> run for LAT edges -> hold until the result is taken.
module wsum_ctrl #(
  parameter int LAT    = 18,
  parameter int LEVELS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic load,
  output logic busy,
  output logic capture
);
  import wsum_pkg::*;

  localparam int CW = $clog2(LAT + 1);

  wsum_state_e   state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (in_valid) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == CW'(LAT - 1)) state_q <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
  assign load      = in_ready & in_valid;
  assign busy      = (state_q == ST_RUN);
  // the root emits bit 0 once every level has registered it
  assign capture   = busy && (cnt_q >= CW'(LEVELS));
endmodule

// File: rtl/wsum_tree.sv
module wsum_tree #(
  parameter int N  = 8,
  parameter int WW = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [N*WW-1:0]               in_weights,
  input  logic [N-1:0]                  in_bits,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [WW+$clog2(N)-1:0]       out_sum
);
  localparam int LEVELS = $clog2(N);
  localparam int SW     = WW + LEVELS;
  localparam int LAT    = SW + LEVELS;
  localparam int NODES  = 2 * N - 1;

  logic load, busy, capture;
  // heap order: leaves 0..N-1, then each level follows the one below it
  logic [NODES-1:0] node;

  wsum_ctrl #(.LAT(LAT), .LEVELS(LEVELS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load      (load),
    .busy      (busy),
    .capture   (capture)
  );

  for (genvar g = 0; g < N; g++) begin : g_leaf
    wsum_serial_node #(.WW(WW), .SW(SW)) u_sn (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .shift   (busy),
      .weight  (in_weights[g*WW +: WW]),
      .x_bit   (in_bits[g]),
      .ser_bit (node[g])
    );
  end

  for (genvar lv = 1; lv <= LEVELS; lv++) begin : g_lvl
    localparam int OFF  = 2 * N - ((2 * N) >> lv);
    localparam int COFF = 2 * N - ((2 * N) >> (lv - 1));
    for (genvar k = 0; k < (N >> lv); k++) begin : g_node
      wsum_bit_adder u_add (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .en    (busy),
        .a     (node[COFF + 2*k]),
        .b     (node[COFF + 2*k + 1]),
        .s     (node[OFF + k])
      );
    end
  end

  wsum_sipo #(.SW(SW)) u_sipo (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (capture),
    .din   (node[NODES-1]),
    .q     (out_sum)
  );
endmodule

// File: rtl/wsum_tree_chk.sv
module wsum_tree_chk #(
  parameter int N  = 8,
  parameter int WW = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [N*WW-1:0]         in_weights,
  input logic [N-1:0]            in_bits,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [WW+$clog2(N)-1:0] out_sum
);
  localparam int LEVELS = $clog2(N);
  localparam int SW     = WW + LEVELS;
  localparam int LAT    = SW + LEVELS;
  localparam int LCW    = $clog2(LAT + 2) + 1;

  logic               accept;
  logic signed [31:0] acc;
  logic               has_min;
  logic signed [31:0] exp_q;
  logic [LCW-1:0]     lat_q;

  assign accept = in_valid & in_ready;

  always_comb begin
    acc     = '0;
    has_min = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (in_bits[i]) acc = acc + 32'(signed'(in_weights[i*WW +: WW]));
      else            acc = acc - 32'(signed'(in_weights[i*WW +: WW]));
      if (in_weights[i*WW +: WW] == {1'b1, {(WW-1){1'b0}}}) has_min = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
      lat_q <= LCW'(LAT + 1);
    end else if (accept) begin
      exp_q <= acc;
      lat_q <= '0;
    end else if (lat_q < LCW'(LAT + 1)) begin
      lat_q <= lat_q + LCW'(1);
    end
  end

  // R2 R3 R7 R8: result equals the sum captured at acceptance
  a_r3_sum_matches: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_sum == exp_q[SW-1:0]));

  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_q == LCW'(LAT)));

  a_r5_one_row: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

  // R8: operand range the sum width is sized for
  a_r8_weight_range: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !has_min);
endmodule

bind wsum_tree wsum_tree_chk #(.N(N), .WW(WW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_weights (in_weights),
  .in_bits    (in_bits),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_sum    (out_sum)
);

// File: tb/tb_wsum_tree.sv
module tb_wsum_tree;
  localparam int N       = 8;
  localparam int WW      = 12;
  localparam int LEVELS  = $clog2(N);
  localparam int SW      = WW + LEVELS;
  localparam int LAT     = SW + LEVELS;
  localparam int CLK_PER = 10;
  localparam int WMAX    = (1 << (WW - 1)) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [N*WW-1:0]   in_weights = '0;
  logic [N-1:0]      in_bits = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [SW-1:0]     out_sum;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PER/2) clk = ~clk;

  wsum_tree #(.N(N), .WW(WW)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_weights (in_weights),
    .in_bits    (in_bits),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_sum    (out_sum)
  );

  function automatic int exp_sum(input logic [N*WW-1:0] w, input logic [N-1:0] b);
    int acc = 0;
    for (int i = 0; i < N; i++) begin
      int wv = int'(signed'(w[i*WW +: WW]));
      acc = b[i] ? acc + wv : acc - wv;
    end
    return acc;
  endfunction

  function automatic logic [N*WW-1:0] fill(input int v);
    logic [N*WW-1:0] r;
    for (int i = 0; i < N; i++) r[i*WW +: WW] = WW'(v);
    return r;
  endfunction

  function automatic logic [N*WW-1:0] rand_w();
    logic [N*WW-1:0] r;
    for (int i = 0; i < N; i++) r[i*WW +: WW] = WW'(int'($urandom_range(0, 2*WMAX)) - WMAX);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // One row through the block, checked for latency, value, hold and release.
  task automatic run_row(input logic [N*WW-1:0] w, input logic [N-1:0] b,
                         input int hold, input bit poke, input string req);
    int edges;
    int expv;
    int got;
    expv = exp_sum(w, b);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_weights = w; in_bits = b;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R5 busy", int'(in_ready), 0);
    edges = 1;
    if (poke) begin
      // junk offered while busy must be refused and leave no trace
      in_valid = 1'b1; in_weights = rand_w(); in_bits = N'($urandom);
      repeat (3) begin @(negedge clk); edges++; end
      in_valid = 1'b0;
    end
    while (!out_valid && edges < LAT + 8) begin @(negedge clk); edges++; end
    edges--;
    chk(edges == LAT, "R4 latency", edges, LAT);
    got = int'($signed(out_sum));
    chk(got == expv, req, got, expv);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(out_valid == 1'b1 && int'($signed(out_sum)) == expv, "R6 hold",
          int'($signed(out_sum)), expv);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R6 release",
        int'({out_valid, in_ready}), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [N*WW-1:0] w;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset", int'({in_ready, out_valid}), 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 after release", int'({in_ready, out_valid}), 2);

    // R2: a single nonzero weight, each polarity of its input bit
    w = '0; w[3*WW +: WW] = WW'(777);
    run_row(w, N'(1) << 3, 0, 0, "R2 plus");
    run_row(w, '0, 0, 0, "R2 minus");
    w = '0; w[0 +: WW] = WW'(-5);
    run_row(w, '0, 1, 0, "R2 neg weight bit0");
    // R8 extremes
    run_row(fill(WMAX), '1, 0, 0, "R8 max");
    run_row(fill(WMAX), '0, 0, 0, "R8 min");
    run_row(fill(-WMAX), '1, 2, 0, "R8 min neg");
    // R7: a carry-heavy row followed at once by a small one
    run_row(fill(-1), '1, 0, 0, "R7 first");
    w = '0; w[WW +: WW] = WW'(3);
    run_row(w, '1, 0, 0, "R7 second");
    run_row('0, '1, 0, 0, "R3 zero");
    // R5: junk offered during reduction
    run_row(rand_w(), N'($urandom), 1, 1, "R5 ignored");

    // R3 random rows with back-pressure
    for (int t = 0; t < 300; t++) begin
      run_row(rand_w(), N'($urandom), int'($urandom_range(0, 3)),
              bit'($urandom_range(0, 1)), "R3 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule